// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block times the low and high halves of the SCL clock for an I2C master. A reference clock is first divided by a power of two chosen by a 3-bit select. Two 5-bit length inputs then set how many divided cycles the low half and the high half last. A fixed overhead is added to every half. The overhead is four cycles when the divider is bypassed and three divided cycles otherwise. It stands for the latency of the line synchronizer and glitch filter.

The block pulls SCL low during the low half and releases it for the high half. It does not start timing the high half until the synchronized and filtered SCL line reads high. A slave that stretches the clock therefore lengthens the high half. Two one-cycle ticks go to the byte engine: one when SCL is driven low, which is the point to change SDA, and one when the high half starts counting, which is the point to sample. Dropping the enable or raising the hold input releases SCL at once and clears all timing state. When timing resumes, it waits for the line to be high and then begins with a high half.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: After reset, and while the block is not enabled, `scl_pull_o`, `fall_tick_o` and `rise_tick_o` are all 0.
- R2: With `div_sel_i` = 0, each low half keeps `scl_pull_o` at 1 for exactly `low_len_i` + 4 reference cycles.
- R3: With `div_sel_i` = n > 0, each low half keeps `scl_pull_o` at 1 for exactly (`low_len_i` + 3) * 2^n reference cycles.
- R4: With SCL looped back as the inverse of `scl_pull_o`, each high half keeps `scl_pull_o` at 0 for 4 + (`high_len_i` + k) * 2^n cycles. Here k = 4 when n = 0 and k = 3 otherwise, and the leading 4 cycles are the line observation latency.
- R5: If a slave holds `scl_i` low after release, the high half starts counting only once `scl_i` has read high. SCL is pulled again 4 + (`high_len_i` + k) * 2^n cycles after the first cycle that `scl_i` reads high.
- R6: A `scl_i` high pulse lasting one reference cycle while the block waits for the line is ignored and does not start the high half.
- R7: A length input of 0 behaves exactly like a length of 1.
- R8: `fall_tick_o` is a one-cycle pulse in the first cycle of each pull. `rise_tick_o` is a single one-cycle pulse per high half, asserted 4 cycles after `scl_i` first reads high, while SCL is released.
- R9: Deasserting `en_i` or asserting `hold_i` releases `scl_pull_o` and stops both ticks from the next cycle on.
- R10: After the block is re-enabled with the line high, `rise_tick_o` appears in the second cycle. The next pull follows (`high_len_i` + k) * 2^n cycles after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable |
| hold_i | input | 1 | Holds the block in internal reset |
| div_sel_i | input | SEL_W (3) | Divider select, divides by 2^n |
| low_len_i | input | LEN_W (5) | Low half length in divided cycles |
| high_len_i | input | LEN_W (5) | High half length in divided cycles |
| scl_i | input | 1 | Observed SCL line level |
| scl_pull_o | output | 1 | Request to drive SCL low |
| fall_tick_o | output | 1 | Pulse at the start of each low half |
| rise_tick_o | output | 1 | Pulse at the start of high half counting |

## Verification
The bench loops the pull output back onto the line and measures every half, both for bypass and for divided settings, including the slowest divider. A design that applied the wrong overhead, or that let the divider drift between halves, would get the widths wrong by a fixed or a growing amount. A slave stretching the clock is modelled with a one-cycle glitch inside the stretch. A filter that passed the glitch would start the high half early and shorten it. Zero lengths, dropping the enable mid-phase, holding the block in reset and re-enabling it are also exercised. These catch a design that leaves SCL pulled, or one that restarts with a stale count.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  localparam int OVH_BYPASS = 4;
  localparam int OVH_PRESC  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sync_q[SYNC_STAGES-1] == sync_q[SYNC_STAGES-2])
        filt_o <= sync_q[SYNC_STAGES-1];
    end
  end

  AST_FILT_AGREES: assert property (@(posedge clk) disable iff (rst)
    (filt_o != $past(filt_o)) |-> ($past(sync_q[SYNC_STAGES-1]) == filt_o)); // R6
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int SEL_W = 3,
  parameter int TGT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TGT_W-1:0] target_i,
  output logic             last_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_mask;
  logic [TGT_W-1:0] pcnt_q;
  logic             div_end;

  assign div_mask = ~({DIV_W{1'b1}} << sel_i);
  assign div_end  = (div_q == div_mask);
  assign last_o   = run_i && div_end && (pcnt_q == target_i - TGT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else if (run_i) begin
      if (div_end) begin
        div_q  <= '0;
        pcnt_q <= pcnt_q + TGT_W'(1);
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !last_o || (target_i == TGT_W'(1) && div_mask == '0)); // R2
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen
  import i2c_sclgen_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int LEN_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic             scl_i,
  output logic             scl_pull_o,
  output logic             fall_tick_o,
  output logic             rise_tick_o
);
  localparam int TGT_W = LEN_W + 1;

  function automatic logic [TGT_W-1:0] phase_target(
    input logic [LEN_W-1:0] len, input logic [SEL_W-1:0] sel);
    logic [TGT_W-1:0] eff;
    eff = (len == '0) ? TGT_W'(1) : TGT_W'(len);
    return eff + ((sel == '0) ? TGT_W'(OVH_BYPASS) : TGT_W'(OVH_PRESC));
  endfunction

  phase_e           st_q;
  logic             active;
  logic             filt;
  logic             last;
  logic             start_high;
  logic             end_high;
  logic             end_low;
  logic             tmr_clr;
  logic             tmr_run;
  logic [TGT_W-1:0] tgt;

  assign active     = en_i && !hold_i;
  assign start_high = (st_q == PH_WAIT) && filt;
  assign end_high   = (st_q == PH_HIGH) && last;
  assign end_low    = (st_q == PH_LOW) && last;
  assign tmr_run    = (st_q == PH_HIGH) || (st_q == PH_LOW);
  assign tmr_clr    = !active || start_high || end_high || end_low;
  assign tgt        = (st_q == PH_LOW) ? phase_target(low_len_i, div_sel_i)
                                       : phase_target(high_len_i, div_sel_i);

  scl_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .line_i (scl_i),
    .filt_o (filt)
  );

  scl_phase_timer #(.SEL_W(SEL_W), .TGT_W(TGT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .sel_i    (div_sel_i),
    .target_i (tgt),
    .last_o   (last)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st_q        <= PH_IDLE;
      scl_pull_o  <= 1'b0;
      fall_tick_o <= 1'b0;
      rise_tick_o <= 1'b0;
    end else begin
      rise_tick_o <= start_high;
      fall_tick_o <= end_high;
      case (st_q)
        PH_IDLE: st_q <= PH_WAIT;
        PH_WAIT: if (start_high) st_q <= PH_HIGH;
        PH_HIGH: if (end_high) begin
          st_q       <= PH_LOW;
          scl_pull_o <= 1'b1;
        end
        PH_LOW: if (end_low) begin
          st_q       <= PH_WAIT;
          scl_pull_o <= 1'b0;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  AST_FALL_WITH_PULL: assert property (@(posedge clk) disable iff (rst)
    fall_tick_o |-> scl_pull_o); // R8
  AST_PULL_ROSE_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull_o) |-> fall_tick_o); // R8
  AST_TICKS_APART: assert property (@(posedge clk) disable iff (rst)
    !(fall_tick_o && rise_tick_o)); // R8
  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rise_tick_o |-> !scl_pull_o); // R5
  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!scl_pull_o && !fall_tick_o && !rise_tick_o)); // R9
endmodule

// File: tb/i2c_scl_rate_gen_tb.sv
module i2c_scl_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       hold = 1'b0;
  logic [2:0] sel = '0;
  logic [4:0] lo = 5'd1;
  logic [4:0] hi = 5'd1;
  logic       stretch = 1'b0;
  logic       scl_line;
  logic       pull, fall_t, rise_t;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;
  assign scl_line = ~pull & ~stretch;

  i2c_scl_rate_gen u_dut (
    .clk(clk), .rst(rst), .en_i(en), .hold_i(hold), .div_sel_i(sel),
    .low_len_i(lo), .high_len_i(hi), .scl_i(scl_line),
    .scl_pull_o(pull), .fall_tick_o(fall_t), .rise_tick_o(rise_t)
  );

  function automatic int exp_phase(int s, int len);
    int eff;
    eff = (len == 0) ? 1 : len;
    return (eff + ((s == 0) ? 4 : 3)) << s;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic setup(int s, int l, int h);
    @(negedge clk);
    en = 1'b0;
    sel = 3'(s); lo = 5'(l); hi = 5'(h);
    repeat (4) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic run_period(int s_len, int g_at);
    int n, lowc, highc, ri, rc, e_lo, e_hi;
    string rl, rh;
    e_lo = exp_phase(int'(sel), int'(lo));
    e_hi = exp_phase(int'(hi) == 0 ? 0 : int'(sel), int'(hi));
    e_hi = exp_phase(int'(sel), int'(hi));
    rl = (sel == 0) ? "R2" : "R3";
    rh = (g_at >= 0) ? "R6" : ((s_len > 0) ? "R5" : "R4");
    if (lo == 0) rl = "R7";
    if (hi == 0) rh = "R7";
    n = 0;
    while (!fall_t && n < 20000) begin @(negedge clk); n++; end
    chk("R8 pull at fall tick", int'(pull), 1);
    if (s_len > 0) stretch = 1'b1;
    lowc = 0;
    while (pull && lowc < 20000) begin lowc++; @(negedge clk); end
    highc = 0; ri = -1; rc = 0;
    while (!pull && highc < 20000) begin
      if (rise_t) begin ri = highc; rc++; end
      if (highc == g_at) stretch = 1'b0;
      if (highc == g_at + 1) stretch = 1'b1;
      if (highc == s_len) stretch = 1'b0;
      highc++;
      @(negedge clk);
    end
    chk(rl, lowc, e_lo);
    chk(rh, highc, s_len + 4 + e_hi);
    chk("R8 rise position", ri, s_len + 4);
    chk("R8 rise count", rc, 1);
    chk("R8 fall tick at pull", int'(fall_t), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned r;
    int s, l, h, n;
    r = $urandom(32'd4711);
    repeat (5) @(negedge clk);
    chk("R1 reset pull", int'(pull), 0);
    chk("R1 reset ticks", int'(fall_t | rise_t), 0);
    @(negedge clk) rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 disabled pull", int'(pull), 0);
    chk("R1 disabled ticks", int'(fall_t | rise_t), 0);

    // directed: bypass, slowest divider, zero lengths
    setup(0, 1, 1);     run_period(0, -1); run_period(0, -1);
    setup(0, 31, 31);   run_period(0, -1);
    setup(7, 1, 2);     run_period(0, -1);
    setup(0, 0, 0);     run_period(0, -1);
    setup(2, 0, 3);     run_period(0, -1);
    // stretch and glitch (R5, R6)
    setup(1, 4, 5);     run_period(0, -1); run_period(12, -1);
    setup(0, 3, 2);     run_period(0, -1); run_period(15, 5);

    // constrained random
    for (int i = 0; i < 12; i++) begin
      s = int'($urandom % 8);
      l = (s >= 5) ? int'($urandom % 6) : int'($urandom % 32);
      h = (s >= 5) ? int'($urandom % 6) : int'($urandom % 32);
      setup(s, l, h);
      run_period(0, -1);
      run_period(0, -1);
    end

    // R9: disable mid low phase, then hold mid low phase
    setup(0, 10, 10);
    n = 0;
    while (!fall_t && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R9 enable off releases", int'(pull), 0);
    repeat (8) @(negedge clk);
    chk("R9 stays released", int'(pull | fall_t | rise_t), 0);

    // R10: re-enable with line high
    en = 1'b1;
    @(negedge clk);
    chk("R10 no tick first cycle", int'(rise_t), 0);
    @(negedge clk);
    chk("R10 rise tick second cycle", int'(rise_t), 1);
    n = 0;
    while (!fall_t && n < 2000) begin @(negedge clk); n++; end
    chk("R10 high after restart", n, exp_phase(0, 10));
    @(negedge clk) hold = 1'b1;
    @(negedge clk);
    chk("R9 hold releases", int'(pull), 0);
    repeat (8) @(negedge clk);
    chk("R9 hold keeps released", int'(pull | fall_t | rise_t), 0);
    hold = 1'b0;
    run_period(0, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule